// File: doc/BRIEF.md
# Fractional-Rate Pulse-Width Modulator with Deferred Update

This block generates one pulse-width modulated output from a single 32-bit control word. The output rate is set by a fractional step that is added to a phase accumulator on every clock. The accumulator is as wide as the step, so the output frequency is step × f_clk ÷ 2^STEP_W. The duty cycle is set by an 8-bit divisor that works the inverted way: a larger divisor gives a shorter high time.

Software writes the word through a plain register port (write strobe, write data, read data). The step and divisor fields go into a staged copy first. They reach the running generator only after software raises the update request bit. The hardware then clears that bit at the next output cycle start. A write that arrives while a request is still pending does not change the staged fields. Instead it sets a sticky drop flag. A parameter selects a stricter variant in which the enable bit can only be turned on once no update is pending.

Top module: `pwm_frac`

## Requirements
- R1: After reset, read data is all zero, the output is low and the drop flag is clear.
- R2: Control word fields: bit 31 enable, bit 30 update request, bit 29 drop flag (read-only, present when 8+STEP_W ≤ 29), bits [8+STEP_W-1:8] step, bits [7:0] divisor. Read data returns enable, request, drop flag and the staged step and divisor.
- R3: With a constant step S, the accumulator wraps every 2^STEP_W ÷ S clocks. With STEP_W=16 and S=512, one output period is 128 clocks.
- R4: While enabled, the output is high in a cycle when the top 8 accumulator bits are strictly greater than the live divisor. With a step of 256, divisor 0 gives 255 high clocks out of 256, divisor 255 gives none, and divisor 100 gives 155.
- R5: A write that leaves the update request at 0 changes the staged fields only. The running output keeps its duty.
- R6: A pending update request is honoured only at a cycle start: an accumulator wrap while enabled, or any clock while disabled. At that clock the staged fields become live and the request bit clears.
- R7: A write while the request bit reads 1 leaves the staged fields and the request unchanged. It sets the drop flag, which then stays set until reset.
- R8: A write with enable 0 forces the output low from the next clock on and restarts the accumulator. Staged fields are kept for readback.
- R9: In the default variant, a single write may set enable and the update request together, and both read back as 1.
- R10: In the strict variant (BYPASS=1), a write that turns enable on is ignored for the enable bit if the request is pending or is being set by that same write.
- R11: The first clock after enable turns on counts as a cycle start, so a request written together with enable clears one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| pwm_o | output | 1 | Modulated output |
| drop_err_o | output | 1 | Sticky flag: a write arrived while an update was pending |

## Verification
The hardest case to reach is a write that lands while an update is still pending. While the generator runs, the request clears at a wrap whose timing the ports do not show. The bench therefore disables the output first. A request then clears on the very next clock, so a second write issued in the cycle straight after the first is sure to see the request still set. The deferral itself is checked by measuring high-clock counts over whole 256-clock windows, before and after each request, at known step and divisor values.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned UPD_BIT  = 30;
  localparam int unsigned ERR_BIT  = 29;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned STEP_LSB = 8;
endpackage

// File: rtl/pwm_frac_regs.sv
module pwm_frac_regs
  import pwm_frac_pkg::*;
#(
  parameter int unsigned STEP_W = 16,
  parameter bit          BYPASS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              boundary,
  output logic              en_q,
  output logic              upd_q,
  output logic              err_q,
  output logic              commit,
  output logic [STEP_W-1:0] step_stg,
  output logic [DIV_W-1:0]  div_stg,
  output logic [STEP_W-1:0] step_live,
  output logic [DIV_W-1:0]  div_live
);
  logic              take;
  logic              en_wr;
  logic              en_d, upd_d, err_d;
  logic [STEP_W-1:0] step_wr;
  logic [DIV_W-1:0]  div_wr;
  logic              unused_wbits;

  assign step_wr      = wdata[STEP_LSB +: STEP_W];
  assign div_wr       = wdata[DIV_W-1:0];
  assign unused_wbits = ^wdata;

  generate
    if (BYPASS) begin : g_strict
      assign en_wr = wdata[EN_BIT] & (en_q | ~(upd_q | wdata[UPD_BIT]));
    end else begin : g_relaxed
      assign en_wr = wdata[EN_BIT];
    end
  endgenerate

  always_comb begin
    commit = upd_q & boundary;
    take   = we & ~upd_q;
    en_d   = we ? en_wr : en_q;
    upd_d  = upd_q & ~commit;
    if (take && wdata[UPD_BIT]) upd_d = 1'b1;
    err_d  = err_q | (we & upd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      upd_q <= upd_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_stg <= '0;
      div_stg  <= '0;
    end else if (take) begin
      step_stg <= step_wr;
      div_stg  <= div_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_live <= '0;
      div_live  <= '0;
    end else if (commit) begin
      step_live <= step_stg;
      div_live  <= div_stg;
    end
  end
endmodule

// File: rtl/pwm_frac_phase.sv
module pwm_frac_phase
  import pwm_frac_pkg::*;
#(
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              commit,
  input  logic [STEP_W-1:0] step_live,
  input  logic [STEP_W-1:0] step_stg,
  input  logic [DIV_W-1:0]  div_live,
  output logic              boundary,
  output logic              pwm
);
  localparam int unsigned TOP_LSB = STEP_W - DIV_W;

  logic [STEP_W-1:0] acc_q, acc_d;
  logic [STEP_W:0]   inc_sum;
  logic              first_q;

  always_comb begin
    inc_sum  = {1'b0, acc_q} + {1'b0, step_live};
    boundary = ~en | first_q | inc_sum[STEP_W];
    if (!en)         acc_d = '0;
    else if (commit) acc_d = acc_q + step_stg;
    else             acc_d = inc_sum[STEP_W-1:0];
    pwm = en & (acc_q[STEP_W-1:TOP_LSB] > div_live);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      first_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      first_q <= ~en;
    end
  end
endmodule

// File: rtl/pwm_frac.sv
module pwm_frac
  import pwm_frac_pkg::*;
#(
  parameter int unsigned STEP_W = 16,
  parameter bit          BYPASS = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        pwm_o,
  output logic        drop_err_o
);
  localparam bit HAS_ERR_BIT = (STEP_LSB + STEP_W <= ERR_BIT);

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic              en_q, upd_q, err_q, commit, boundary;
  logic [STEP_W-1:0] step_stg, step_live;
  logic [DIV_W-1:0]  div_stg, div_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  pwm_frac_regs #(.STEP_W(STEP_W), .BYPASS(BYPASS)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .we(reg_we), .wdata(reg_wdata),
    .boundary(boundary), .en_q(en_q), .upd_q(upd_q), .err_q(err_q),
    .commit(commit), .step_stg(step_stg), .div_stg(div_stg),
    .step_live(step_live), .div_live(div_live)
  );

  pwm_frac_phase #(.STEP_W(STEP_W)) u_phase (
    .clk(clk), .rst_n(rst_q_n), .en(en_q), .commit(commit),
    .step_live(step_live), .step_stg(step_stg), .div_live(div_live),
    .boundary(boundary), .pwm(pwm_o)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[EN_BIT]  = en_q;
    reg_rdata[UPD_BIT] = upd_q;
    if (HAS_ERR_BIT) reg_rdata[ERR_BIT] = err_q;
    reg_rdata[STEP_LSB +: STEP_W] = step_stg;
    reg_rdata[DIV_W-1:0] = div_stg;
  end
  assign drop_err_o = err_q;
endmodule

// File: rtl/pwm_frac_chk.sv
module pwm_frac_chk #(
  parameter int unsigned STEP_W = 16,
  parameter bit          BYPASS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              pwm_o,
  input logic              en_q,
  input logic              upd_q,
  input logic              err_q,
  input logic              boundary,
  input logic              commit,
  input logic [STEP_W-1:0] step_stg,
  input logic [7:0]        div_stg,
  input logic [STEP_W-1:0] step_live,
  input logic [7:0]        div_live
);
  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[31]) |=> !pwm_o);

  assert_upd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !boundary) |=> upd_q);

  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !upd_q);

  assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(step_live) && $stable(div_live)));

  assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && upd_q) |=> ($stable(step_stg) && $stable(div_stg) && err_q));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  generate
    if (BYPASS) begin : g_strict_chk
      assert_en_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && (upd_q || (reg_we && reg_wdata[30]))) |=> !en_q);
    end
  endgenerate
endmodule

bind pwm_frac pwm_frac_chk #(.STEP_W(STEP_W), .BYPASS(BYPASS)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .pwm_o(pwm_o), .en_q(en_q), .upd_q(upd_q), .err_q(err_q),
  .boundary(boundary), .commit(commit), .step_stg(step_stg),
  .div_stg(div_stg), .step_live(step_live), .div_live(div_live)
);

// File: tb/test_pwm_frac.sv
`timescale 1ns/1ps
module test_pwm_frac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, reg_we_b;
  logic [31:0] reg_wdata, reg_wdata_b;
  logic [31:0] reg_rdata, reg_rdata_b;
  logic        pwm_o, pwm_b;
  logic        drop_err_o, drop_err_b;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #2.5 clk = ~clk;

  pwm_frac #(.STEP_W(16), .BYPASS(1'b0)) i_pwm_frac (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_o(pwm_o), .drop_err_o(drop_err_o));

  pwm_frac #(.STEP_W(16), .BYPASS(1'b1)) i_pwm_frac_byp (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we_b), .reg_wdata(reg_wdata_b),
    .reg_rdata(reg_rdata_b), .pwm_o(pwm_b), .drop_err_o(drop_err_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic wr_b(input logic [31:0] d);
    reg_we_b = 1'b1; reg_wdata_b = d;
    @(posedge clk); #1;
    reg_we_b = 1'b0;
  endtask

  task automatic count_high(input int n, input bit use_b, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cnt += use_b ? int'(pwm_b) : int'(pwm_o);
    end
  endtask

  task automatic wait_clear(output int cyc);
    cyc = 0;
    while (reg_rdata[30] && cyc < 400) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  task automatic t_reset;
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 pwm", {31'b0, pwm_o}, 32'h0);
    check("R1 drop", {31'b0, drop_err_o}, 32'h0);
  endtask

  task automatic t_layout;
    wr(32'h0012345A);
    check("R2 readback", reg_rdata, 32'h0012345A);
  endtask

  task automatic t_start;
    int c;
    wr(32'hC0010064);
    check("R9 enable with request", reg_rdata[31:30], 32'h3);
    @(posedge clk); #1;
    check("R11 request clears one clock after enable", {31'b0, reg_rdata[30]}, 32'h0);
    count_high(256, 1'b0, c);
    check("R4 divisor 100", c, 155);
  endtask

  task automatic t_staged;
    int c, w;
    wr(32'h80010000);
    check("R5 staged readback", reg_rdata, 32'h80010000);
    count_high(256, 1'b0, c);
    check("R5 duty unchanged", c, 155);
    wr(32'hC0010000);
    check("R6 request pending", {31'b0, reg_rdata[30]}, 32'h1);
    wait_clear(w);
    check("R6 clears within a period", {31'b0, (w >= 1 && w <= 257)}, 32'h1);
    count_high(256, 1'b0, c);
    check("R4 divisor 0", c, 255);
    wr(32'hC00100FF);
    wait_clear(w);
    count_high(256, 1'b0, c);
    check("R4 divisor 255", c, 0);
  endtask

  task automatic t_period;
    int c, w;
    wr(32'hC0020065);
    wait_clear(w);
    count_high(128, 1'b0, c);
    check("R3 one period step 512", c, 77);
    count_high(256, 1'b0, c);
    check("R3 two periods step 512", c, 154);
  endtask

  task automatic t_disable;
    int c;
    wr(32'h00020065);
    check("R8 low next clock", {31'b0, pwm_o}, 32'h0);
    check("R8 fields kept", reg_rdata, 32'h00020065);
    count_high(64, 1'b0, c);
    check("R8 stays low", c, 0);
  endtask

  task automatic t_drop;
    wr(32'h40010020);
    wr(32'h40010077);
    check("R7 staged kept, flag set", reg_rdata, 32'h20010020);
    check("R7 drop port", {31'b0, drop_err_o}, 32'h1);
    wr(32'h00010011);
    check("R7 sticky after accepted write", reg_rdata, 32'h20010011);
  endtask

  task automatic t_bypass;
    int c;
    wr_b(32'hC0010064);
    check("R10 enable refused with request", reg_rdata_b[31:30], 32'h1);
    @(posedge clk); #1;
    check("R10 request cleared while off", {31'b0, reg_rdata_b[30]}, 32'h0);
    wr_b(32'h80010064);
    check("R10 enable accepted", {31'b0, reg_rdata_b[31]}, 32'h1);
    count_high(256, 1'b1, c);
    check("R10 duty after enable", c, 155);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0; reg_wdata = '0;
    reg_we_b = 1'b0; reg_wdata_b = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_layout();
    t_start();
    t_staged();
    t_period();
    t_disable();
    t_drop();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule